// File: doc/BRIEF.md
# Sixteen-bit Clear-on-Match Timer

This block is a 16-bit up-counter with three compare registers (A, B, C), a capture register used as a counter limit, an interrupt-mask register and a write-one-to-clear interrupt-flag register. An external prescaler supplies a one-cycle enable pulse, and the counter advances only on cycles where that pulse is high. A 4-bit mode value selects one of three behaviours. In free-running mode the counter wraps from 0xFFFF to 0. In limit-A mode the counter clears when it reaches compare register A. In limit-capture mode it clears when it reaches the capture register.

Software reaches the block through a plain single-cycle write port. Each write carries a select code and a 16-bit word. All state can be read back on dedicated output buses. Each of the five interrupt lines is the logical AND of one flag bit and the mask bit at the same position. A flag is set whatever its mask bit holds. The port has no back-pressure: every write is taken in the cycle it is presented.

Top module: `tmr16_ctc`

## Requirements
- R1: The select codes are: 0 mode-low, 1 mode-high, 2 counter, 3 compare A, 4 compare B, 5 compare C, 6 capture, 7 mask, 8 flag-clear. A mode-low write (select 0) loads data bits 1:0 into mode bits 1:0, and a mode-high write (select 1) loads data bits 4:3 into mode bits 3:2. The result appears on `mode_o`.
- R2: In mode 0, each tick adds one to the counter. A tick taken while the counter reads 0xFFFF wraps it to 0 and sets flag bit 0 (overflow).
- R3: The counter changes only on a cycle where `tick_i` is high, or where a counter write occurs.
- R4: In mode 4, a tick taken while the counter equals compare A loads 0 instead of the incremented value.
- R5: In mode 12, a tick taken while the counter equals the capture register loads 0 and sets flag bit 5 (capture).
- R6: In modes 0, 4 and 12, a tick taken while the counter equals compare A, B or C sets flag bit 1, 2 or 3 respectively.
- R7: A counter write (select 2) loads the data and discards any tick in the same cycle. The next tick still advances the counter by one, but it raises no flag, no clear and no overflow.
- R8: A capture write (select 6) takes effect only while the mode is 12. In any other mode it leaves `cap_o` unchanged.
- R9: In any mode other than 0, 4 and 12, ticks leave the counter unchanged and set no flag.
- R10: A flag-clear write (select 8) clears each flag whose data bit is 1. If a flag is set by the hardware in the same cycle it is cleared, the flag stays set. Flag bits 4, 6 and 7 always read 0.
- R11: Each interrupt output is high exactly when its flag bit and its mask bit are both 1: overflow bit 0, compare A bit 1, compare B bit 2, compare C bit 3, capture bit 5. A mask write (select 7) keeps only those bits of data 7:0.
- R12: After reset, all registers (counter, compares, capture, mode, mask and flags) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 4 | Write select code (see R1) |
| wr_data_i | input | 16 | Write data |
| mode_o | output | 4 | Current mode value |
| cnt_o | output | 16 | Counter value |
| cmp_a_o | output | 16 | Compare register A |
| cmp_b_o | output | 16 | Compare register B |
| cmp_c_o | output | 16 | Compare register C |
| cap_o | output | 16 | Capture register |
| mask_o | output | 8 | Interrupt mask |
| flags_o | output | 8 | Interrupt flags |
| irq_ovf_o | output | 1 | Overflow interrupt |
| irq_cmpa_o | output | 1 | Compare A interrupt |
| irq_cmpb_o | output | 1 | Compare B interrupt |
| irq_cmpc_o | output | 1 | Compare C interrupt |
| irq_cap_o | output | 1 | Capture interrupt |

## Verification
Two situations are hard to reach from the ports. The first is a blocked tick that lands exactly on a compare value or on the limit. The second is a hardware flag set in the same cycle as a software clear of that flag. The bench reaches both by holding `tick_i` low, writing the counter, and then releasing ticks one at a time. The single tick is aligned with the clear write, so the two collide in a known cycle. A random phase that mixes writes and ticks follows, and a behavioural model is compared against every output on every cycle.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int FLAG_W = 8;
  localparam int NCMP = 3;
  localparam int NSRC = 5;
  localparam int BIT_OVF  = 0;
  localparam int BIT_CMPA = 1;
  localparam int BIT_CAP  = 5;
  localparam logic [FLAG_W-1:0] FLAG_USED = 8'h2F;

  typedef enum logic [3:0] {
    SEL_MODE_LO = 4'd0,
    SEL_MODE_HI = 4'd1,
    SEL_CNT     = 4'd2,
    SEL_CMPA    = 4'd3,
    SEL_CMPB    = 4'd4,
    SEL_CMPC    = 4'd5,
    SEL_CAP     = 4'd6,
    SEL_MASK    = 4'd7,
    SEL_FLAG    = 4'd8
  } sel_e;

  localparam logic [3:0] MODE_FREE    = 4'd0;
  localparam logic [3:0] MODE_CLR_A   = 4'd4;
  localparam logic [3:0] MODE_CLR_CAP = 4'd12;

  // maps an interrupt source index to its flag bit position
  function automatic int src_bit(input int idx);
    case (idx)
      0: src_bit = BIT_OVF;
      1: src_bit = 1;
      2: src_bit = 2;
      3: src_bit = 3;
      default: src_bit = BIT_CAP;
    endcase
  endfunction
endpackage

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [3:0]               wr_sel,
  input  logic [W-1:0]             wr_data,
  output logic [3:0]               mode,
  output logic [NCMP-1:0][W-1:0]   cmp,
  output logic [W-1:0]             cap,
  output logic [FLAG_W-1:0]        mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
      cap  <= '0;
      mask <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_MODE_LO) mode[1:0] <= wr_data[1:0];
      if (wr_sel == SEL_MODE_HI) mode[3:2] <= wr_data[4:3];
      if (wr_sel == SEL_CAP && mode == MODE_CLR_CAP) cap <= wr_data;
      if (wr_sel == SEL_MASK) mask <= wr_data[FLAG_W-1:0] & FLAG_USED;
    end
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    localparam logic [3:0] MY_SEL = 4'(int'(SEL_CMPA) + i);
    always_ff @(posedge clk) begin
      if (!rst_n) cmp[i] <= '0;
      else if (wr_en && wr_sel == MY_SEL) cmp[i] <= wr_data;
    end
  end
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [3:0]               mode,
  input  logic [NCMP-1:0][W-1:0]   cmp,
  input  logic [W-1:0]             cap,
  input  logic                     load_en,
  input  logic [W-1:0]             load_val,
  output logic [W-1:0]             cnt,
  output logic [FLAG_W-1:0]        set_flags
);
  localparam logic [W-1:0] MAXV = '1;

  logic            blk;
  logic            active;
  logic [NCMP-1:0] hit;
  logic [W-1:0]    nxt;

  assign active = (mode == MODE_FREE) || (mode == MODE_CLR_A) || (mode == MODE_CLR_CAP);

  for (genvar i = 0; i < NCMP; i++) begin : g_hit
    assign hit[i] = (cnt == cmp[i]);
  end

  always_comb begin
    nxt       = cnt;
    set_flags = '0;
    if (load_en) begin
      nxt = load_val;
    end else if (tick && active) begin
      if (blk) begin
        nxt = cnt + 1'b1;
      end else begin
        for (int i = 0; i < NCMP; i++) set_flags[BIT_CMPA+i] = hit[i];
        if (mode == MODE_CLR_A && hit[0]) begin
          nxt = '0;
        end else if (mode == MODE_CLR_CAP && cnt == cap) begin
          nxt = '0;
          set_flags[BIT_CAP] = 1'b1;
        end else begin
          nxt = cnt + 1'b1;
          if (cnt == MAXV) set_flags[BIT_OVF] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else begin
      cnt <= nxt;
      if (load_en) blk <= 1'b1;
      else if (tick) blk <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr16_flags.sv
module tmr16_flags
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_flags,
  input  logic              clr_en,
  input  logic [FLAG_W-1:0] clr_data,
  input  logic [FLAG_W-1:0] mask,
  output logic [FLAG_W-1:0] flags,
  output logic [NSRC-1:0]   irq
);
  logic [FLAG_W-1:0] clr_vec;
  assign clr_vec = clr_en ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= ((flags & ~clr_vec) | set_flags) & FLAG_USED;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_irq
    localparam int B = src_bit(s);
    assign irq[s] = flags[B] & mask[B];
  end
endmodule

// File: rtl/tmr16_ctc.sv
module tmr16_ctc
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [3:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic [3:0]   mode_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmp_a_o,
  output logic [W-1:0] cmp_b_o,
  output logic [W-1:0] cmp_c_o,
  output logic [W-1:0] cap_o,
  output logic [7:0]   mask_o,
  output logic [7:0]   flags_o,
  output logic         irq_ovf_o,
  output logic         irq_cmpa_o,
  output logic         irq_cmpb_o,
  output logic         irq_cmpc_o,
  output logic         irq_cap_o
);
  logic [NCMP-1:0][W-1:0] cmp;
  logic [FLAG_W-1:0]      set_flags;
  logic [NSRC-1:0]        irq;
  logic                   cnt_load;
  logic                   flag_clr;

  assign cnt_load = wr_en_i && (wr_sel_i == SEL_CNT);
  assign flag_clr = wr_en_i && (wr_sel_i == SEL_FLAG);

  tmr16_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_sel(wr_sel_i),
    .wr_data(wr_data_i), .mode(mode_o), .cmp(cmp), .cap(cap_o), .mask(mask_o)
  );

  tmr16_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .mode(mode_o), .cmp(cmp),
    .cap(cap_o), .load_en(cnt_load), .load_val(wr_data_i), .cnt(cnt_o),
    .set_flags(set_flags)
  );

  tmr16_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_flags(set_flags), .clr_en(flag_clr),
    .clr_data(wr_data_i[FLAG_W-1:0]), .mask(mask_o), .flags(flags_o), .irq(irq)
  );

  assign cmp_a_o    = cmp[0];
  assign cmp_b_o    = cmp[1];
  assign cmp_c_o    = cmp[2];
  assign irq_ovf_o  = irq[0];
  assign irq_cmpa_o = irq[1];
  assign irq_cmpb_o = irq[2];
  assign irq_cmpc_o = irq[3];
  assign irq_cap_o  = irq[4];
endmodule

// File: rtl/tmr16_ctc_chk.sv
module tmr16_ctc_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic         wr_en_i,
  input logic [3:0]   wr_sel_i,
  input logic [3:0]   mode_o,
  input logic [W-1:0] cnt_o,
  input logic [W-1:0] cmp_a_o,
  input logic [W-1:0] cap_o,
  input logic [7:0]   mask_o,
  input logic [7:0]   flags_o,
  input logic         irq_cmpa_o
);
  logic cnt_wr, cap_wr, blocked, active;
  assign cnt_wr = wr_en_i && wr_sel_i == 4'd2;
  assign cap_wr = wr_en_i && wr_sel_i == 4'd6;
  assign active = mode_o == 4'd0 || mode_o == 4'd4 || mode_o == 4'd12;

  always_ff @(posedge clk) begin
    if (!rst_n) blocked <= 1'b0;
    else if (cnt_wr) blocked <= 1'b1;
    else if (tick_i) blocked <= 1'b0;
  end

  p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cnt_wr) |=> $stable(cnt_o));
  p_wrap_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd0 && tick_i && !cnt_wr && !blocked && cnt_o == '1) |=> (cnt_o == '0 && flags_o[0]));
  p_clear_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd4 && tick_i && !cnt_wr && !blocked && cnt_o == cmp_a_o) |=> cnt_o == '0);
  p_clear_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd12 && tick_i && !cnt_wr && !blocked && cnt_o == cap_o) |=> (cnt_o == '0 && flags_o[5]));
  p_cap_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_wr && mode_o != 4'd12) |=> $stable(cap_o));
  p_idle_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cnt_wr) |=> $stable(cnt_o));
  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[4] == 1'b0 && flags_o[7:6] == 2'b00));
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmpa_o == (flags_o[1] && mask_o[1]));
endmodule

bind tmr16_ctc tmr16_ctc_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .mode_o(mode_o), .cnt_o(cnt_o), .cmp_a_o(cmp_a_o), .cap_o(cap_o),
  .mask_o(mask_o), .flags_o(flags_o), .irq_cmpa_o(irq_cmpa_o)
);

// File: tb/tmr16_ctc_tb_top.sv
`timescale 1ns/1ps
module tmr16_ctc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [3:0] wr_sel_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [3:0] mode_o;
  logic [15:0] cnt_o, cmp_a_o, cmp_b_o, cmp_c_o, cap_o;
  logic [7:0] mask_o, flags_o;
  logic irq_ovf_o, irq_cmpa_o, irq_cmpb_o, irq_cmpc_o, irq_cap_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr16_ctc dut_i (.*);

  // behavioural reference model
  int m_cnt, m_a, m_b, m_c, m_cap, m_mode, m_mask, m_flags;
  bit m_blk;

  always @(posedge clk) begin
    int setf, clr, nc;
    bit act;
    if (!rst_n) begin
      m_cnt = 0; m_a = 0; m_b = 0; m_c = 0; m_cap = 0;
      m_mode = 0; m_mask = 0; m_flags = 0; m_blk = 0;
    end else begin
      setf = 0; clr = 0; nc = m_cnt;
      act = (m_mode == 0 || m_mode == 4 || m_mode == 12);
      if (wr_en_i && wr_sel_i == 2) begin
        nc = wr_data_i; m_blk = 1;
      end else if (tick_i) begin
        if (act) begin
          if (m_blk) nc = (m_cnt + 1) % 65536;
          else begin
            if (m_cnt == m_a) setf |= 2;
            if (m_cnt == m_b) setf |= 4;
            if (m_cnt == m_c) setf |= 8;
            if (m_mode == 4 && m_cnt == m_a) nc = 0;
            else if (m_mode == 12 && m_cnt == m_cap) begin nc = 0; setf |= 32; end
            else begin
              nc = (m_cnt + 1) % 65536;
              if (m_cnt == 65535) setf |= 1;
            end
          end
        end
        m_blk = 0;
      end
      if (wr_en_i) begin
        case (wr_sel_i)
          0: m_mode = (m_mode & 12) | (wr_data_i & 3);
          1: m_mode = (m_mode & 3) | (((wr_data_i >> 3) & 3) << 2);
          3: m_a = wr_data_i;
          4: m_b = wr_data_i;
          5: m_c = wr_data_i;
          6: if (m_mode == 12) m_cap = wr_data_i;
          7: m_mask = wr_data_i & 8'h2F;
          8: clr = wr_data_i & 8'hFF;
          default: ;
        endcase
      end
      m_flags = ((m_flags & ~clr) | setf) & 8'h2F;
      m_cnt = nc;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 counter vs model", cnt_o, m_cnt);
      chk("R1 mode vs model", mode_o, m_mode);
      chk("R6 flags vs model", flags_o, m_flags);
      chk("R8 capture vs model", cap_o, m_cap);
      chk("R11 mask vs model", mask_o, m_mask);
      chk("R6 compare regs vs model", {cmp_a_o, cmp_b_o, cmp_c_o}, {m_a[15:0], m_b[15:0], m_c[15:0]});
      chk("R11 irq vs model", {irq_cap_o, irq_cmpc_o, irq_cmpb_o, irq_cmpa_o, irq_ovf_o},
          {m_flags[5] & m_mask[5], m_flags[3] & m_mask[3], m_flags[2] & m_mask[2],
           m_flags[1] & m_mask[1], m_flags[0] & m_mask[0]});
    end
  end

  task automatic wr(input int sel, input int data);
    wr_en_i = 1; wr_sel_i = 4'(sel); wr_data_i = 16'(data);
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic ticks(input int n);
    tick_i = 1;
    repeat (n) @(negedge clk);
    tick_i = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    chk("R12 counter after reset", cnt_o, 0);
    chk("R12 flags after reset", flags_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R12 mode after reset", mode_o, 0);
    chk("R12 capture after reset", cap_o, 0);

    // R6: free-running, compare hits
    wr(3, 5); wr(4, 7); wr(5, 9); wr(7, 16'hFF);
    chk("R11 mask keeps defined bits", mask_o, 8'h2F);
    ticks(12);
    chk("R6 all compare flags", flags_o, 8'h0E);
    chk("R2 counter after 12 ticks", cnt_o, 12);

    // R3: no ticks, counter holds
    held = cnt_o;
    repeat (5) @(negedge clk);
    chk("R3 counter held without tick", cnt_o, held);

    // R11: mask gating
    wr(7, 8'h02);
    chk("R11 irq A enabled", irq_cmpa_o, 1);
    chk("R11 irq B masked", irq_cmpb_o, 0);
    chk("R11 flag B still set", flags_o[2], 1);

    // R10: clear and set-wins collision
    wr(8, 8'hFF);
    chk("R10 flags cleared", flags_o, 0);
    wr(3, 31); wr(2, 30);
    ticks(1);                   // blocked tick: 30 -> 31
    chk("R7 blocked tick advances", cnt_o, 31);
    tick_i = 1; wr(8, 8'h02); tick_i = 0;   // match on A coincides with clear
    chk("R10 set wins over clear", flags_o[1], 1);
    chk("R10 counter past match", cnt_o, 32);

    // R2: overflow wrap
    wr(8, 8'hFF);
    wr(2, 16'hFFFD);
    ticks(4);
    chk("R2 counter wrapped", cnt_o, 1);
    chk("R2 overflow flag", flags_o[0], 1);

    // R4 / R7 in mode 4
    wr(0, 0); wr(1, 8'h08);
    chk("R1 mode 4", mode_o, 4);
    wr(3, 10); wr(8, 8'hFF);
    wr(2, 10);
    ticks(1);
    chk("R7 write to limit skips clear", cnt_o, 11);
    chk("R7 write to limit skips flag", flags_o[1], 0);
    wr(2, 3);
    ticks(8);
    chk("R4 clear on compare A", cnt_o, 0);
    chk("R4 compare A flag", flags_o[1], 1);
    ticks(2);
    chk("R4 restart after clear", cnt_o, 2);

    // R8: capture ignored outside mode 12
    wr(6, 16'h1234);
    chk("R8 capture write ignored", cap_o, 0);

    // R9: idle mode
    wr(0, 2);
    held = cnt_o;
    wr(8, 8'hFF);
    ticks(5);
    chk("R9 counter held in mode 6", cnt_o, held);
    chk("R9 no flags in mode 6", flags_o, 0);

    // R5: mode 12
    wr(0, 0); wr(1, 8'h18);
    chk("R1 mode 12", mode_o, 12);
    wr(6, 6);
    chk("R8 capture written in mode 12", cap_o, 6);
    wr(3, 16'h100); wr(4, 16'h100); wr(5, 16'h100);
    wr(2, 0);
    ticks(7);
    chk("R5 clear on capture", cnt_o, 0);
    chk("R5 capture flag", flags_o[5], 1);

    // random mix, compared every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      int sel, data;
      tick_i = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 5) == 0) begin
        sel = $urandom_range(0, 8);
        data = (sel == 2 || sel >= 3 && sel <= 6) ? $urandom_range(0, 40) : $urandom_range(0, 255);
        if (sel == 1) data = ($urandom_range(0, 1) != 0) ? 8'h08 : 8'h18;
        if ($urandom_range(0, 30) == 0) data = 16'hFFF0;
        wr(sel, data);
      end else begin
        @(negedge clk);
      end
    end
    tick_i = 0;
    @(negedge clk);
    finish_run();
  end
endmodule